// File: doc/BRIEF.md
# Branch-and-Exchange Fetch Sequencer

This block drives the memory bus for a branch that may also switch the processor between its 32-bit instruction set and its 16-bit instruction set. When the core's decode logic pulses `start`, the block captures the current program counter, the current instruction-set state bit and a target value from a register. It then runs exactly three read cycles on the bus.

The first of these cycles is a prefetch that cannot be cancelled. It reads from the current PC plus twice the old instruction width, and it uses the old access-size code and the old state bit. The second and third cycles refill the pipeline from the branch target, using the width, access-size code and state bit of the new instruction set.

One cycle after the third fetch, `done` pulses. At the same time the block presents the address the core should fetch next and the new state bit. The block holds both values until the next branch completes. The instruction decode, the register file, the datapath and the memory are outside the block.

Top module: `bx_fetch_seq`

## Requirements
- R1: After a synchronous active-high reset, and whenever the block is idle, the outputs take safe values: `bus_req_n`=1, `bus_opc_n`=1, `bus_wr_n`=0, `bus_seq`=0, `bus_size`=0, `bus_addr`=0 and `busy`=0. Reset also sets `next_pc`=0, `next_state`=0 and `done`=0.
- R2: In the cycle after an accepted `start` (fetch 1), `bus_addr` equals the captured PC plus 8 when the old state is 0, or plus 4 when it is 1, wrapping at the address width. `bus_size` is 2 for old state 0 and 1 for old state 1, `bus_state` equals the old state, and `bus_seq`=0.
- R3: In fetch 2, `bus_addr` equals the destination. `bus_size` is the new state's code (2 for state 0, 1 for state 1), `bus_state` equals the new state, and `bus_seq`=1.
- R4: In fetch 3, `bus_addr` equals the destination plus the new width (4 for state 0, 2 for state 1). `bus_size` and `bus_state` carry the new state's values, and `bus_seq`=1.
- R5: During all three fetches, `bus_wr_n`=0, `bus_req_n`=0, `bus_opc_n`=0 and `busy`=1.
- R6: The new state is bit 0 of `reg_val`. The destination is `reg_val` with bit 0 cleared when the new state is 1, and with bits 1:0 cleared when the new state is 0.
- R7: `done` is high for exactly the one cycle after fetch 3. In that cycle, `next_pc` equals the destination plus twice the new width and `next_state` equals the new state. Both hold their values until the next sequence completes.
- R8: A `start` that arrives while a sequence is running is ignored, together with any change on `cur_pc`, `cur_state` and `reg_val`. The running sequence finishes unchanged, and no further sequence follows it.
- R9: A `start` in the `done` cycle is accepted, and its fetch 1 appears in the next cycle.
- R10: While idle, `bus_state` equals `next_state`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a branch-and-exchange sequence (accepted only when idle) |
| cur_pc | input | ADDR_W | Program counter at the branch |
| cur_state | input | 1 | Instruction-set state before the branch (0 = 32-bit, 1 = 16-bit) |
| reg_val | input | ADDR_W | Register value holding the target and new state bit |
| bus_addr | output | ADDR_W | Fetch address |
| bus_size | output | 2 | Access size code (2 = word, 1 = halfword, 0 idle) |
| bus_wr_n | output | 1 | Read/write strobe, low for read |
| bus_req_n | output | 1 | Memory request, active low |
| bus_seq | output | 1 | Sequential-access flag |
| bus_opc_n | output | 1 | Opcode fetch flag, active low |
| bus_state | output | 1 | Instruction-set state presented with the access |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| next_pc | output | ADDR_W | Next fetch address after the branch |
| next_state | output | 1 | Instruction-set state after the branch |

## Verification
The bench builds the block with `ADDR_W` set to 16. With that width, random program counters and targets often land in the top few bytes of the address space, so the fetch-1 increment, the fetch-3 increment and the final `next_pc` all wrap around zero in many sequences. All four old-state/new-state combinations are covered, and random low bits in `reg_val` exercise the alignment masking. Directed sequences cover a `start` held through a running sequence and a `start` issued in the `done` cycle.

// File: rtl/bx_fetch_seq.sv
module bx_fetch_seq #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              cur_state,
  input  logic [ADDR_W-1:0] reg_val,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic              bus_wr_n,
  output logic              bus_req_n,
  output logic              bus_seq,
  output logic              bus_opc_n,
  output logic              bus_state,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] next_pc,
  output logic              next_state
);

  typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_TGT, PH_NXT} phase_t;

  phase_t            ph_q;
  logic [ADDR_W-1:0] pc_q, dest_q;
  logic              old_q, new_q;

  logic [ADDR_W-1:0] step_old2, step_new, step_new2, dest_d;

  assign step_old2 = {{(ADDR_W-4){1'b0}}, ~old_q, old_q, 2'b00};
  assign step_new  = {{(ADDR_W-3){1'b0}}, ~new_q, new_q, 1'b0};
  assign step_new2 = {{(ADDR_W-4){1'b0}}, ~new_q, new_q, 2'b00};
  assign dest_d    = reg_val[0] ? {reg_val[ADDR_W-1:1], 1'b0}
                                : {reg_val[ADDR_W-1:2], 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q       <= PH_IDLE;
      pc_q       <= '0;
      dest_q     <= '0;
      old_q      <= 1'b0;
      new_q      <= 1'b0;
      done       <= 1'b0;
      next_pc    <= '0;
      next_state <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph_q)
        PH_IDLE: if (start) begin
          ph_q   <= PH_PRE;
          pc_q   <= cur_pc;
          old_q  <= cur_state;
          new_q  <= reg_val[0];
          dest_q <= dest_d;
        end
        PH_PRE:  ph_q <= PH_TGT;
        PH_TGT:  ph_q <= PH_NXT;
        default: begin
          ph_q       <= PH_IDLE;
          done       <= 1'b1;
          next_pc    <= dest_q + step_new2;
          next_state <= new_q;
        end
      endcase
    end
  end

  assign busy      = (ph_q != PH_IDLE);
  assign bus_req_n = ~busy;
  assign bus_opc_n = ~busy;
  assign bus_wr_n  = 1'b0;
  assign bus_seq   = (ph_q == PH_TGT) || (ph_q == PH_NXT);

  always_comb begin
    case (ph_q)
      PH_PRE: begin
        bus_addr  = pc_q + step_old2;
        bus_size  = old_q ? 2'd1 : 2'd2;
        bus_state = old_q;
      end
      PH_TGT: begin
        bus_addr  = dest_q;
        bus_size  = new_q ? 2'd1 : 2'd2;
        bus_state = new_q;
      end
      PH_NXT: begin
        bus_addr  = dest_q + step_new;
        bus_size  = new_q ? 2'd1 : 2'd2;
        bus_state = new_q;
      end
      default: begin
        bus_addr  = '0;
        bus_size  = 2'd0;
        bus_state = next_state;
      end
    endcase
  end

endmodule

// File: rtl/bx_fetch_seq_chk.sv
module bx_fetch_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic              bus_wr_n,
  input logic              bus_req_n,
  input logic              bus_seq,
  input logic              bus_opc_n,
  input logic              bus_state,
  input logic              busy,
  input logic              done
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (bus_req_n && bus_opc_n && !bus_seq && bus_size == 2'd0));

  // R5
  fetch_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!bus_req_n && !bus_opc_n && !bus_wr_n));

  // R2
  pre_then_target_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !bus_seq) |=> (busy && bus_seq));

  // R3
  size_matches_state_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bus_size == (bus_state ? 2'd1 : 2'd2)));

  // R6
  target_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_seq && !$past(bus_seq)) |->
      (bus_state ? (bus_addr[0] == 1'b0) : (bus_addr[1:0] == 2'b00)));

  // R4
  refill_state_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_seq && $past(busy && bus_seq)) |-> $stable(bus_state) && $stable(bus_size));

  // R7
  done_after_third_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_seq && $past(busy && bus_seq)) |=> (done && !busy));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind bx_fetch_seq bx_fetch_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_size(bus_size),
  .bus_wr_n(bus_wr_n), .bus_req_n(bus_req_n), .bus_seq(bus_seq),
  .bus_opc_n(bus_opc_n), .bus_state(bus_state), .busy(busy), .done(done)
);

// File: tb/bx_fetch_seq_tb.sv
module bx_fetch_seq_tb;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [AW-1:0] cur_pc, reg_val;
  logic          cur_state;
  logic [AW-1:0] bus_addr, next_pc;
  logic [1:0]    bus_size;
  logic          bus_wr_n, bus_req_n, bus_seq, bus_opc_n, bus_state;
  logic          busy, done, next_state;

  int checks = 0;
  int fails  = 0;
  bit prestarted = 0;

  always #2 clk = ~clk;

  bx_fetch_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cur_pc(cur_pc), .cur_state(cur_state),
    .reg_val(reg_val), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wr_n(bus_wr_n), .bus_req_n(bus_req_n), .bus_seq(bus_seq),
    .bus_opc_n(bus_opc_n), .bus_state(bus_state), .busy(busy), .done(done),
    .next_pc(next_pc), .next_state(next_state)
  );

  function automatic logic [AW-1:0] width_of(input logic st);
    return st ? AW'(2) : AW'(4);
  endfunction

  function automatic logic [1:0] size_of(input logic st);
    return st ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [AW-1:0] dest_of(input logic [AW-1:0] rv);
    return rv[0] ? (rv & ~AW'(1)) : (rv & ~AW'(3));
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_bus(input string tag, input logic [AW-1:0] a, input logic st, input logic sq);
    chk(bus_addr == a, {tag, " addr"}, bus_addr, a);
    chk(bus_size == size_of(st), {tag, " size"}, bus_size, size_of(st));
    chk(bus_state == st, {tag, " state"}, bus_state, st);
    chk(bus_seq == sq, {tag, " seq"}, bus_seq, sq);
    // R5
    chk(!bus_wr_n && !bus_req_n && !bus_opc_n && busy, "R5 strobes",
        {bus_wr_n, bus_req_n, bus_opc_n, busy}, 4'b0001);
  endtask

  // mode 0 plain, 1 = start held/inputs scrambled while busy (R8), 2 = chain next start in done cycle (R9)
  task automatic run_bx(input logic [AW-1:0] pc, input logic st, input logic [AW-1:0] rv,
                        input int mode, input logic [AW-1:0] pc2, input logic st2,
                        input logic [AW-1:0] rv2);
    logic          nt;
    logic [AW-1:0] d;
    nt = rv[0];
    d  = dest_of(rv);
    if (!prestarted) begin
      @(negedge clk);
      start = 1'b1; cur_pc = pc; cur_state = st; reg_val = rv;
    end
    prestarted = 0;
    @(negedge clk);
    if (mode == 2) chk(busy && !done, "R9 chained fetch 1 started", busy, 1);
    chk_bus("R2 fetch1", pc + (width_of(st) << 1), st, 1'b0);
    if (mode == 1) begin
      start = 1'b1; cur_pc = AW'($urandom); cur_state = ~st; reg_val = AW'($urandom);
    end else start = 1'b0;
    @(negedge clk);
    chk_bus("R3 fetch2", d, nt, 1'b1);
    // R6
    chk(nt ? (bus_addr[0] == 0) : (bus_addr[1:0] == 0), "R6 alignment", bus_addr, d);
    @(negedge clk);
    chk_bus("R4 fetch3", d + width_of(nt), nt, 1'b1);
    start = 1'b0;
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R7 done pulse", {done, busy}, 2'b10);
    chk(next_pc == d + (width_of(nt) << 1), "R7 next_pc", next_pc, d + (width_of(nt) << 1));
    chk(next_state == nt, "R7 next_state", next_state, nt);
    if (mode == 2) begin
      start = 1'b1; cur_pc = pc2; cur_state = st2; reg_val = rv2;
      prestarted = 1;
      return;
    end
    @(negedge clk);
    chk(!done && !busy, "R8 R7 no extra activity", {done, busy}, 2'b00);
    chk(bus_req_n && bus_opc_n && bus_addr == 0, "R1 idle bus", {bus_req_n, bus_opc_n}, 2'b11);
    chk(bus_state == nt, "R10 idle state", bus_state, nt);
    chk(next_pc == d + (width_of(nt) << 1), "R7 next_pc held", next_pc, d + (width_of(nt) << 1));
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; start = 1'b0; cur_pc = '0; cur_state = 1'b0; reg_val = '0;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    rst = 1'b0; start = 1'b0;
    // R1
    chk(!busy && !done && bus_req_n && bus_opc_n && !bus_wr_n && !bus_seq,
        "R1 reset strobes", {busy, done, bus_req_n, bus_opc_n, bus_wr_n, bus_seq}, 6'b001100);
    chk(bus_addr == 0 && bus_size == 0 && next_pc == 0 && !next_state && !bus_state,
        "R1 reset values", bus_addr, 0);
    @(negedge clk);
    chk(!busy, "R1 start during reset ignored", busy, 0);

    run_bx(16'h1000, 1'b0, 16'h2001, 0, 0, 0, 0);
    run_bx(16'h3002, 1'b1, 16'h4003, 0, 0, 0, 0);
    run_bx(16'h5006, 1'b1, 16'h6000, 0, 0, 0, 0);
    run_bx(16'h7000, 1'b0, 16'h8006, 0, 0, 0, 0);
    run_bx(16'hFFFC, 1'b0, 16'hFFFE, 0, 0, 0, 0);
    run_bx(16'hFFFE, 1'b1, 16'hFFFF, 0, 0, 0, 0);
    run_bx(16'h0120, 1'b0, 16'h0443, 1, 0, 0, 0);
    run_bx(16'h0200, 1'b1, 16'h0881, 2, 16'hFFFA, 1'b0, 16'hFFF5);
    run_bx(16'hFFFA, 1'b0, 16'hFFF5, 0, 0, 0, 0);

    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] p, r;
      p = AW'($urandom);
      r = AW'($urandom);
      if (i % 5 == 0) p = p | 16'hFFF0;
      if (i % 7 == 0) r = r | 16'hFFF8;
      run_bx(p, p[0] ^ r[3], r, (i % 4 == 1) ? 1 : 0, 0, 0, 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule